// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block is the downstream routing decision of a PCI-to-PCI style bridge. It keeps the programmable bus-number registers and the three forwarding windows (I/O, non-prefetchable memory and prefetchable memory). These registers are written and read through a byte-enabled configuration port at their standard header offsets. For every request presented on the primary side, it reports whether the request belongs to the secondary side.

Each window register keeps only the upper address bits of its base and limit. The effective base has zeros in the low bits. The effective limit has ones there: 0xFFF for I/O, giving 4 KB steps, and 0xFFFFF for memory, giving 1 MB steps. Two parameters select the optional wider decoders. One adds 32-bit I/O through the I/O upper registers. The other adds 64-bit prefetchable memory through the prefetchable upper registers. A capability nibble in the low bits of the base and limit registers advertises each wider decoder.

Configuration requests are routed by bus number. A request for the secondary bus turns into a Type 0 access. A request for a bus deeper in the hierarchy passes on unchanged. The decision outputs are combinational from the request inputs and the stored registers. A configuration write takes effect at the next rising clock edge.

Top module: `bridge_window_decode`

## Requirements
- R1: After reset every window and bus register reads zero, except the fixed capability values. With the wide I/O decoder, offset 1Ch bits 3:0 and 11:8 read 1. With the 64-bit prefetchable decoder, offset 24h bits 3:0 and 19:16 read 1. With all registers zero, both memory windows cover 0x0–0xFFFFF.
- R2: A write to the dword at `cfg_addr_i[7:2]` changes only the bytes whose `cfg_be_i` bit is set, and only the writable bits of those bytes. The writable bits are: 18h bits 23:0 (primary 7:0, secondary 15:8, subordinate 23:16); 1Ch bits 7:4 and 15:12; 20h and 24h bits 15:4 and 31:20; 28h, 2Ch and 30h, all bits. Reads are combinational. Offsets outside 18h–33h read zero.
- R3: The I/O window runs from {30h[15:0], 1Ch[7:4], 0x000} to {30h[31:16], 1Ch[15:12], 0xFFF}. An I/O request inside it, with address bits 63:32 zero, is forwarded.
- R4: The memory window runs from {20h[15:4], 0x00000} to {20h[31:20], 0xFFFFF}. It matches only addresses whose bits 63:32 are zero.
- R5: The prefetchable window runs from {28h, 24h[15:4], 0x00000} to {2Ch, 24h[31:20], 0xFFFFF}. This is a 64-bit compare.
- R6: A window whose base is greater than its limit matches nothing.
- R7: A memory request is forwarded if it falls in either memory window. An I/O request is forwarded only on an I/O window match. Neither request type is forwarded by the other type's window.
- R8: A configuration request for bus == secondary gives `fwd_o`=1 and `cfg_type0_o`=1. One with secondary < bus <= subordinate gives `fwd_o`=1 and `cfg_type0_o`=0. Any other bus gives both 0. The primary bus register has no effect on decoding.
- R9: `req_type_i` encodes 0 = memory, 1 = I/O, 2 = configuration, 3 = idle. An idle request drives `fwd_o`, `cfg_type0_o` and `win_hit_o` to 0. `win_hit_o` bit 0 is the I/O window, bit 1 the memory window and bit 2 the prefetchable window. Each bit is set only for a request of its own type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset (dword selected by bits 7:2) |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data of the addressed dword |
| req_type_i | input | 2 | Request kind: 0 memory, 1 I/O, 2 configuration, 3 idle |
| req_addr_i | input | 64 | Request address (memory or I/O) |
| req_bus_i | input | 8 | Target bus of a configuration request |
| fwd_o | output | 1 | Request is forwarded to the secondary side |
| cfg_type0_o | output | 1 | Configuration request becomes a Type 0 access |
| win_hit_o | output | 3 | Window matches {prefetchable, memory, I/O} |

## Verification
The bench builds the block with its default parameters, so both the 32-bit I/O and the 64-bit prefetchable decoders are present. These defaults make reachable an I/O window above 64 KB and a prefetchable window above 4 GB. They also make reachable a case where a 32-bit address with clear upper bits fails the prefetchable window. Window edges are probed one unit inside and one unit outside each bound. Partial byte-enable writes, a base above its limit, and configuration buses at the secondary, inside the range, at the subordinate and outside it are driven as directed cases.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  typedef enum logic [1:0] {
    REQ_MEM  = 2'd0,
    REQ_IO   = 2'd1,
    REQ_CFG  = 2'd2,
    REQ_IDLE = 2'd3
  } req_kind_e;

  localparam int unsigned FIRST_DW = 6;   // offset 18h
  localparam int unsigned LAST_DW  = 12;  // offset 30h
  localparam int unsigned NUM_DW   = LAST_DW - FIRST_DW + 1;
endpackage

// File: rtl/bwd_regs.sv
module bwd_regs #(
  parameter bit IO_32 = 1'b1,
  parameter bit PF_64 = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [7:0]  sec_o,
  output logic [7:0]  sub_o,
  output logic [3:0]  io_base_o,
  output logic [3:0]  io_lim_o,
  output logic [15:0] io_base_up_o,
  output logic [15:0] io_lim_up_o,
  output logic [11:0] mem_base_o,
  output logic [11:0] mem_lim_o,
  output logic [11:0] pf_base_o,
  output logic [11:0] pf_lim_o,
  output logic [31:0] pf_base_up_o,
  output logic [31:0] pf_lim_up_o
);
  import bwd_pkg::*;

  function automatic logic [31:0] wr_mask(int unsigned idx);
    case (idx)
      0:       return 32'h00FF_FFFF;
      1:       return 32'h0000_F0F0;
      2, 3:    return 32'hFFF0_FFF0;
      4, 5:    return PF_64 ? 32'hFFFF_FFFF : 32'h0;
      6:       return IO_32 ? 32'hFFFF_FFFF : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] ro_val(int unsigned idx);
    case (idx)
      1:       return IO_32 ? 32'h0000_0101 : 32'h0;
      3:       return PF_64 ? 32'h0001_0001 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  logic [5:0]               dw_idx;
  logic [31:0]              be_mask;
  logic [NUM_DW-1:0][31:0]  dw;

  assign dw_idx  = addr_i[7:2];
  assign be_mask = {{8{be_i[3]}}, {8{be_i[2]}}, {8{be_i[1]}}, {8{be_i[0]}}};

  for (genvar g = 0; g < NUM_DW; g++) begin : g_dw
    localparam logic [31:0] WM = wr_mask(g);
    logic [31:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q <= '0;
      else if (we_i && dw_idx == 6'(FIRST_DW + g))
        q <= (q & ~(be_mask & WM)) | (wdata_i & be_mask & WM);
    end
    assign dw[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_DW; i++)
      if (dw_idx == 6'(FIRST_DW + i)) rdata_o = dw[i] | ro_val(i);
  end

  assign sec_o        = dw[0][15:8];
  assign sub_o        = dw[0][23:16];
  assign io_base_o    = dw[1][7:4];
  assign io_lim_o     = dw[1][15:12];
  assign mem_base_o   = dw[2][15:4];
  assign mem_lim_o    = dw[2][31:20];
  assign pf_base_o    = dw[3][15:4];
  assign pf_lim_o     = dw[3][31:20];
  assign pf_base_up_o = dw[4];
  assign pf_lim_up_o  = dw[5];
  assign io_base_up_o = dw[6][15:0];
  assign io_lim_up_o  = dw[6][31:16];

  a_r2_bus_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && dw_idx == 6'd6 && be_i[1]) |=> (sec_o == $past(wdata_i[15:8])));

  a_r2_be_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && dw_idx == 6'd6 && !be_i[2]) |=> $stable(sub_o));
endmodule

// File: rtl/bwd_window.sv
module bwd_window #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] limit_i,
  input  logic [W-1:0] addr_i,
  output logic         hit_o
);
  // comparing upper bits only equals comparing zero-filled base and one-filled limit
  logic en;
  assign en    = base_i <= limit_i;
  assign hit_o = en && (addr_i >= base_i) && (addr_i <= limit_i);
endmodule

// File: rtl/bwd_bus_route.sv
module bwd_bus_route (
  input  logic [7:0] sec_i,
  input  logic [7:0] sub_i,
  input  logic [7:0] bus_i,
  output logic       in_range_o,
  output logic       is_sec_o
);
  assign is_sec_o   = bus_i == sec_i;
  assign in_range_o = is_sec_o || (bus_i > sec_i && bus_i <= sub_i);
endmodule

// File: rtl/bridge_window_decode.sv
module bridge_window_decode #(
  parameter bit IO_32 = 1'b1,
  parameter bit PF_64 = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_addr_i,
  input  logic [3:0]  cfg_be_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic [1:0]  req_type_i,
  input  logic [63:0] req_addr_i,
  input  logic [7:0]  req_bus_i,
  output logic        fwd_o,
  output logic        cfg_type0_o,
  output logic [2:0]  win_hit_o
);
  import bwd_pkg::*;

  logic [7:0]  sec, sub;
  logic [3:0]  io_base, io_lim;
  logic [15:0] io_base_up, io_lim_up;
  logic [11:0] mem_base, mem_lim, pf_base, pf_lim;
  logic [31:0] pf_base_up, pf_lim_up;

  bwd_regs #(.IO_32(IO_32), .PF_64(PF_64)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .be_i(cfg_be_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .sec_o(sec), .sub_o(sub),
    .io_base_o(io_base), .io_lim_o(io_lim),
    .io_base_up_o(io_base_up), .io_lim_up_o(io_lim_up),
    .mem_base_o(mem_base), .mem_lim_o(mem_lim),
    .pf_base_o(pf_base), .pf_lim_o(pf_lim),
    .pf_base_up_o(pf_base_up), .pf_lim_up_o(pf_lim_up)
  );

  req_kind_e kind;
  assign kind = req_kind_e'(req_type_i);

  logic hi32_zero;
  assign hi32_zero = req_addr_i[63:32] == '0;

  logic io_win, mem_win, pf_win;
  logic io_ok, pf_ok;

  if (IO_32) begin : g_io32
    bwd_window #(.W(20)) u_io (
      .base_i({io_base_up, io_base}), .limit_i({io_lim_up, io_lim}),
      .addr_i(req_addr_i[31:12]), .hit_o(io_win));
    assign io_ok = hi32_zero;
    logic unused_io;
    assign unused_io = 1'b0;
  end else begin : g_io16
    bwd_window #(.W(4)) u_io (
      .base_i(io_base), .limit_i(io_lim),
      .addr_i(req_addr_i[15:12]), .hit_o(io_win));
    assign io_ok = hi32_zero && req_addr_i[31:16] == '0;
    logic unused_io;
    assign unused_io = ^{io_base_up, io_lim_up};
  end

  bwd_window #(.W(12)) u_mem (
    .base_i(mem_base), .limit_i(mem_lim),
    .addr_i(req_addr_i[31:20]), .hit_o(mem_win));

  if (PF_64) begin : g_pf64
    bwd_window #(.W(44)) u_pf (
      .base_i({pf_base_up, pf_base}), .limit_i({pf_lim_up, pf_lim}),
      .addr_i(req_addr_i[63:20]), .hit_o(pf_win));
    assign pf_ok = 1'b1;
    logic unused_pf;
    assign unused_pf = 1'b0;
  end else begin : g_pf32
    bwd_window #(.W(12)) u_pf (
      .base_i(pf_base), .limit_i(pf_lim),
      .addr_i(req_addr_i[31:20]), .hit_o(pf_win));
    assign pf_ok = hi32_zero;
    logic unused_pf;
    assign unused_pf = ^{pf_base_up, pf_lim_up};
  end

  logic bus_in, bus_sec;
  bwd_bus_route u_bus (
    .sec_i(sec), .sub_i(sub), .bus_i(req_bus_i),
    .in_range_o(bus_in), .is_sec_o(bus_sec));

  logic hit_io, hit_mem, hit_pf;
  assign hit_io  = kind == REQ_IO  && io_ok && io_win;
  assign hit_mem = kind == REQ_MEM && hi32_zero && mem_win;
  assign hit_pf  = kind == REQ_MEM && pf_ok && pf_win;

  always_comb begin
    unique case (kind)
      REQ_MEM: fwd_o = hit_mem || hit_pf;
      REQ_IO:  fwd_o = hit_io;
      REQ_CFG: fwd_o = bus_in;
      default: fwd_o = 1'b0;
    endcase
  end

  assign cfg_type0_o = kind == REQ_CFG && bus_sec;
  assign win_hit_o   = {hit_pf, hit_mem, hit_io};

  logic unused_low;
  assign unused_low = ^{req_addr_i[11:0]};

  a_r8_type0_forwarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_type0_o |-> fwd_o);

  a_r7_io_by_io_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == REQ_IO && fwd_o) |-> win_hit_o[0]);

  a_r7_mem_by_mem_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == REQ_MEM && fwd_o) |-> (win_hit_o[1] || win_hit_o[2]));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == REQ_IDLE) |-> (!fwd_o && !cfg_type0_o && win_hit_o == 3'b000));

  a_r9_hits_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind != REQ_MEM) |-> $onehot0(win_hit_o));
endmodule

// File: tb/bridge_window_decode_tb.sv
`timescale 1ns/1ps
module bridge_window_decode_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [3:0]  cfg_be_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic [1:0]  req_type_i = 2'd3;
  logic [63:0] req_addr_i = '0;
  logic [7:0]  req_bus_i = '0;
  logic        fwd_o, cfg_type0_o;
  logic [2:0]  win_hit_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bridge_window_decode u_dut (.*);

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  kind;
    logic [63:0] addr;
    logic [7:0]  bus;
    logic        fwd;
    logic        t0;
    logic [2:0]  hit;
  } vec_t;

  // Window setup: I/O 0x12000-0x13FFF, mem 0xC0000000-0xC0FFFFFF,
  // pref 0x1_00000000-0x1_3FFFFFFF, sec 2, sub 5
  localparam vec_t VECS [20] = '{
    '{4'd4, 2'd0, 64'h0000_0000_C000_0000, 8'd0, 1'b1, 1'b0, 3'b010}, // R4 low edge
    '{4'd4, 2'd0, 64'h0000_0000_C0FF_FFFF, 8'd0, 1'b1, 1'b0, 3'b010}, // R4 high edge
    '{4'd4, 2'd0, 64'h0000_0000_C100_0000, 8'd0, 1'b0, 1'b0, 3'b000}, // R4 above
    '{4'd4, 2'd0, 64'h0000_0000_BFFF_FFFF, 8'd0, 1'b0, 1'b0, 3'b000}, // R4 below
    '{4'd5, 2'd0, 64'h0000_0001_0000_0000, 8'd0, 1'b1, 1'b0, 3'b100}, // R5 low edge
    '{4'd5, 2'd0, 64'h0000_0001_3FFF_FFFF, 8'd0, 1'b1, 1'b0, 3'b100}, // R5 high edge
    '{4'd5, 2'd0, 64'h0000_0001_4000_0000, 8'd0, 1'b0, 1'b0, 3'b000}, // R5 above
    '{4'd5, 2'd0, 64'h0000_0000_0000_0000, 8'd0, 1'b0, 1'b0, 3'b000}, // R5 upper mismatch
    '{4'd3, 2'd1, 64'h0000_0000_0001_2000, 8'd0, 1'b1, 1'b0, 3'b001}, // R3 low edge
    '{4'd3, 2'd1, 64'h0000_0000_0001_3FFF, 8'd0, 1'b1, 1'b0, 3'b001}, // R3 high edge
    '{4'd3, 2'd1, 64'h0000_0000_0001_4000, 8'd0, 1'b0, 1'b0, 3'b000}, // R3 above
    '{4'd3, 2'd1, 64'h0000_0000_0001_1FFF, 8'd0, 1'b0, 1'b0, 3'b000}, // R3 below
    '{4'd7, 2'd1, 64'h0000_0000_C000_0000, 8'd0, 1'b0, 1'b0, 3'b000}, // R7 io in mem range
    '{4'd7, 2'd0, 64'h0000_0000_0001_2000, 8'd0, 1'b0, 1'b0, 3'b000}, // R7 mem in io range
    '{4'd8, 2'd2, 64'h0,                   8'd2, 1'b1, 1'b1, 3'b000}, // R8 secondary
    '{4'd8, 2'd2, 64'h0,                   8'd5, 1'b1, 1'b0, 3'b000}, // R8 subordinate
    '{4'd8, 2'd2, 64'h0,                   8'd3, 1'b1, 1'b0, 3'b000}, // R8 inside
    '{4'd8, 2'd2, 64'h0,                   8'd6, 1'b0, 1'b0, 3'b000}, // R8 above
    '{4'd8, 2'd2, 64'h0,                   8'd1, 1'b0, 1'b0, 3'b000}, // R8 primary bus
    '{4'd9, 2'd3, 64'h0000_0000_C000_0000, 8'd2, 1'b0, 1'b0, 3'b000}  // R9 idle
  };

  task automatic cfg_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_be_i = be; cfg_wdata_i = d;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0; cfg_be_i = '0;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1;
    checks++;
    if (cfg_rdata_o !== exp) begin
      errors++;
      $display("FAIL %s read %02h: got %08h exp %08h", tag, a, cfg_rdata_o, exp);
    end
  endtask

  task automatic chk_req(input logic [1:0] k, input logic [63:0] ad, input logic [7:0] b,
                         input logic f, input logic t, input logic [2:0] h, input string tag);
    @(negedge clk_i);
    req_type_i = k; req_addr_i = ad; req_bus_i = b;
    #1;
    checks++;
    if ({fwd_o, cfg_type0_o, win_hit_o} !== {f, t, h}) begin
      errors++;
      $display("FAIL %s type %0d addr %h bus %0d: got fwd %b t0 %b hit %b exp fwd %b t0 %b hit %b",
               tag, k, ad, b, fwd_o, cfg_type0_o, win_hit_o, f, t, h);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #12 rst_ni = 1'b1;
    // R1 reset values
    chk_rd(8'h18, 32'h0000_0000, "R1");
    chk_rd(8'h1C, 32'h0000_0101, "R1");
    chk_rd(8'h24, 32'h0001_0001, "R1");
    chk_rd(8'h30, 32'h0000_0000, "R1");
    chk_req(2'd0, 64'h0008_0000, 8'd0, 1'b1, 1'b0, 3'b110, "R1");

    cfg_wr(8'h18, 4'hF, 32'hAA05_0201);
    cfg_wr(8'h1C, 4'hF, 32'h0000_3020);
    cfg_wr(8'h30, 4'hF, 32'h0001_0001);
    cfg_wr(8'h20, 4'hF, 32'hC0F0_C000);
    cfg_wr(8'h24, 4'hF, 32'h3FF0_0000);
    cfg_wr(8'h28, 4'hF, 32'h0000_0001);
    cfg_wr(8'h2C, 4'hF, 32'h0000_0001);
    chk_rd(8'h18, 32'h0005_0201, "R2");
    chk_rd(8'h1C, 32'h0000_3121, "R2");
    chk_rd(8'h24, 32'h3FF1_0001, "R2");
    chk_rd(8'h34, 32'h0000_0000, "R2");

    for (int i = 0; i < 20; i++)
      chk_req(VECS[i].kind, VECS[i].addr, VECS[i].bus, VECS[i].fwd, VECS[i].t0,
              VECS[i].hit, $sformatf("R%0d", VECS[i].rq));

    // R2 partial byte enable: only the secondary byte changes
    cfg_wr(8'h18, 4'b0010, 32'hFFFF_FFFF);
    chk_rd(8'h18, 32'h0005_FF01, "R2");
    chk_req(2'd2, 64'h0, 8'd2, 1'b0, 1'b0, 3'b000, "R2");
    cfg_wr(8'h18, 4'b0010, 32'h0000_0200);
    chk_req(2'd2, 64'h0, 8'd2, 1'b1, 1'b1, 3'b000, "R8");

    // R6 memory base above limit disables window
    cfg_wr(8'h20, 4'b0011, 32'h0000_C100);
    chk_req(2'd0, 64'hC080_0000, 8'd0, 1'b0, 1'b0, 3'b000, "R6");
    // R6 base equal to limit is a single 1 MB unit
    cfg_wr(8'h20, 4'b0011, 32'h0000_C0F0);
    chk_req(2'd0, 64'hC0FF_FFFF, 8'd0, 1'b1, 1'b0, 3'b010, "R6");
    chk_req(2'd0, 64'hC0EF_FFFF, 8'd0, 1'b0, 1'b0, 3'b000, "R6");

    // R2 fixed bits survive an all-ones write
    cfg_wr(8'h1C, 4'hF, 32'hFFFF_FFFF);
    chk_rd(8'h1C, 32'h0000_F1F1, "R2");

    finish_run();
  end
endmodule